// File: doc/BRIEF.md
# Bridge forwarding window decoder

This block keeps the three forwarding windows of a bridge between two buses: one for I/O space, one for non-prefetchable memory and one for prefetchable memory. Software programs them through byte-wide or 16-bit configuration writes into packed base and limit fields. Each field holds only the upper address bits. The block rebuilds full 64-bit base and limit addresses from these fields and applies the fixed granularity of each window. The low bits of a base are taken as zeros, and the low bits of a limit are taken as ones.

Two services use the windows. The first is a membership test: for a transaction address and a space code, the block reports whether the address falls inside the enabled window. The second is a range clip: a requested base and size are trimmed to their overlap with the selected window. The trimmed base and size, or an unmapped result, are returned one cycle later. Every configuration write that touches window state raises a one-cycle update strobe, so that dependent decoders know to re-evaluate.

Top module: `fwd_window_decoder`

## Requirements
- R1: After reset every window is empty (base above limit): no address hits in any space, no update strobe is raised, and a clip against any window is unmapped.
- R2: The I/O window base is the upper nibble of configuration byte 0x1C placed at address bits 15:12. The I/O limit is the upper nibble of byte 0x1D placed the same way, with bits 11:0 forced to ones. An I/O address hits when base <= address <= limit.
- R3: When bit 0 of byte 0x1C is set, the 16-bit register at 0x30 supplies base bits 31:16; when bit 0 of byte 0x1D is set, the 16-bit register at 0x32 supplies limit bits 31:16. When the bit is clear, those upper bits are zero and the upper register has no effect.
- R4: The memory window takes bits 15:4 of the 16-bit register at 0x20 (base) and at 0x22 (limit) as address bits 31:20. Bits 3:0 of those registers are ignored. The limit has bits 19:0 forced to ones.
- R5: The prefetchable window uses the memory encoding on the 16-bit registers at 0x24 (base) and 0x26 (limit). The 32-bit registers at 0x28 (base) and 0x2C (limit) supply address bits 63:32.
- R6: Space codes are 0 = I/O, 1 = memory, 2 = prefetchable, 3 = none. I/O never hits while ioEnable is low. Memory and prefetchable never hit while memEnable is low. Code 3 never hits.
- R7: With cfgWide low, cfgData[7:0] is written to byte cfgAddr. With cfgWide high, cfgData[7:0] goes to cfgAddr and cfgData[15:8] goes to cfgAddr+1. Bytes outside 0x1C, 0x1D and 0x20..0x33 leave every window unchanged.
- R8: cfgUpdate is high for exactly the one cycle after a write that touches byte 0x1C, 0x1D or any byte in 0x20..0x33. A write that touches none of them raises no strobe.
- R9: One cycle after clipReq, clipValid is high. For a mapped result, the clipped base is the larger of the request base and the window base. The clipped end is the smaller of the request end (base+size-1, saturating at all ones) and the window limit. The size is end-base+1.
- R10: A clip is reported unmapped (clipMapped low, base all ones, size 0) when the clipped base exceeds the clipped end, when the request size is 0, when the space is 3, or when the space is disabled.
- R11: The hit output is combinational from the stored window fields. A write is reflected in qHit from the cycle right after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write request |
| cfgWide | input | 1 | 0: byte write, 1: 16-bit write |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgData | input | 16 | Write data (low byte to cfgAddr) |
| ioEnable | input | 1 | I/O space enable from the command register |
| memEnable | input | 1 | Memory space enable from the command register |
| qSpace | input | 2 | Space code of the tested address |
| qAddr | input | 64 | Tested transaction address |
| qHit | output | 1 | Address is inside the enabled window |
| clipReq | input | 1 | Start a range clip |
| clipSpace | input | 2 | Space code of the clip request |
| clipBase | input | 64 | Requested range base |
| clipSize | input | 64 | Requested range size in bytes |
| cfgUpdate | output | 1 | One-cycle strobe after a window write |
| clipValid | output | 1 | Clip result present |
| clipMapped | output | 1 | Clip result overlaps the window |
| clipOutBase | output | 64 | Clipped base, all ones when unmapped |
| clipOutSize | output | 64 | Clipped size, zero when unmapped |

## Verification
The hardest case to reach from the ports is a 64-bit prefetchable window whose upper half differs from the lower memory window. Both halves must hold their own values before an address that is correct only in its low 32 bits can be shown to miss. The stimulus builds this window from several 16-bit writes into the two upper registers. It then probes addresses that differ only in bits 63:32, and clips a request that spans the whole upper 4 GB page. Saturation of the request end is reached by clipping a range that starts near the top of the address space.

// File: rtl/fwdwin_pkg.sv
package fwdwin_pkg;
  localparam int QAW = 64;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 16;
  localparam int NUM_SPACES = 4;
  localparam int NUM_WIN_BYTES = 22;
  localparam int IO_GRAN_BITS = 12;
  localparam int MEM_GRAN_BITS = 20;

  localparam int SL_IO_BASE = 0;
  localparam int SL_IO_LIM = 1;
  localparam int SL_MEM_BASE = 2;
  localparam int SL_MEM_LIM = 4;
  localparam int SL_PF_BASE = 6;
  localparam int SL_PF_LIM = 8;
  localparam int SL_PF_BASE_UP = 10;
  localparam int SL_PF_LIM_UP = 14;
  localparam int SL_IO_BASE_UP = 18;
  localparam int SL_IO_LIM_UP = 20;

  typedef enum logic [1:0] {
    SPACE_IO   = 2'd0,
    SPACE_MEM  = 2'd1,
    SPACE_PREF = 2'd2,
    SPACE_NONE = 2'd3
  } space_e;

  typedef struct packed {
    logic [NUM_WIN_BYTES-1:0]       byteWe;
    logic [NUM_WIN_BYTES-1:0][7:0]  byteData;
    logic                           clipLoad;
  } ctrl_strobe_t;

  // Slot 0/1 map to the two I/O bytes, slots 2.. map to 0x20 upward.
  function automatic logic [CFG_AW-1:0] offOf(int slot);
    if (slot < 2) return CFG_AW'(8'h1C + slot);
    return CFG_AW'(8'h20 + slot - 2);
  endfunction
endpackage

// File: rtl/fwdwin_ctrl.sv
module fwdwin_ctrl
  import fwdwin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgWide,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_DW-1:0] cfgData,
  input  logic              clipReq,
  output ctrl_strobe_t      strobe,
  output logic              cfgUpdate,
  output logic              clipValid
);
  logic [CFG_AW-1:0] hiAddr;
  logic [NUM_WIN_BYTES-1:0] slotWe;
  logic [NUM_WIN_BYTES-1:0][7:0] slotData;
  logic touched;

  assign hiAddr = cfgAddr + CFG_AW'(1);

  for (genvar s = 0; s < NUM_WIN_BYTES; s++) begin : g_slot
    localparam logic [CFG_AW-1:0] SlotOff = offOf(s);
    logic loMatch;
    logic hiMatch;
    assign loMatch = (cfgAddr == SlotOff);
    assign hiMatch = cfgWide && (hiAddr == SlotOff);
    assign slotWe[s] = cfgWrEn && (loMatch || hiMatch);
    assign slotData[s] = hiMatch ? cfgData[15:8] : cfgData[7:0];
  end

  assign touched = |slotWe;

  always_comb begin
    strobe.byteWe = slotWe;
    strobe.byteData = slotData;
    strobe.clipLoad = clipReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgUpdate <= 1'b0;
      clipValid <= 1'b0;
    end else begin
      cfgUpdate <= touched;
      clipValid <= clipReq;
    end
  end
endmodule

// File: rtl/fwdwin_dp.sv
module fwdwin_dp
  import fwdwin_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  ctrl_strobe_t   strobe,
  input  logic           ioEnable,
  input  logic           memEnable,
  input  space_e         qSpace,
  input  logic [QAW-1:0] qAddr,
  output logic           qHit,
  input  space_e         clipSpace,
  input  logic [QAW-1:0] clipBase,
  input  logic [QAW-1:0] clipSize,
  output logic           clipMapped,
  output logic [QAW-1:0] clipOutBase,
  output logic [QAW-1:0] clipOutSize
);
  localparam int MemFieldW = 32 - MEM_GRAN_BITS;
  localparam int IoNibW = 16 - IO_GRAN_BITS;

  logic [IoNibW-1:0]    ioBaseNib, ioLimNib;
  logic                 ioBaseWide, ioLimWide;
  logic [15:0]          ioBaseUp, ioLimUp;
  logic [MemFieldW-1:0] memBaseF, memLimF, pfBaseF, pfLimF;
  logic [31:0]          pfBaseUp, pfLimUp;

  logic [NUM_WIN_BYTES-1:0]      we;
  logic [NUM_WIN_BYTES-1:0][7:0] wd;
  assign we = strobe.byteWe;
  assign wd = strobe.byteData;

  logic unusedLowBits;
  assign unusedLowBits = ^{wd[SL_IO_BASE][3:1], wd[SL_IO_LIM][3:1],
                           wd[SL_MEM_BASE][3:0], wd[SL_MEM_LIM][3:0],
                           wd[SL_PF_BASE][3:0], wd[SL_PF_LIM][3:0]};

  // Field storage; reset leaves every base above its limit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioBaseNib  <= '1;
      ioLimNib   <= '0;
      ioBaseWide <= 1'b0;
      ioLimWide  <= 1'b0;
      ioBaseUp   <= '0;
      ioLimUp    <= '0;
      memBaseF   <= '1;
      memLimF    <= '0;
      pfBaseF    <= '1;
      pfLimF     <= '0;
      pfBaseUp   <= '1;
      pfLimUp    <= '0;
    end else begin
      if (we[SL_IO_BASE]) begin
        ioBaseNib  <= wd[SL_IO_BASE][7:4];
        ioBaseWide <= wd[SL_IO_BASE][0];
      end
      if (we[SL_IO_LIM]) begin
        ioLimNib  <= wd[SL_IO_LIM][7:4];
        ioLimWide <= wd[SL_IO_LIM][0];
      end
      if (we[SL_MEM_BASE])   memBaseF[3:0]  <= wd[SL_MEM_BASE][7:4];
      if (we[SL_MEM_BASE+1]) memBaseF[11:4] <= wd[SL_MEM_BASE+1];
      if (we[SL_MEM_LIM])    memLimF[3:0]   <= wd[SL_MEM_LIM][7:4];
      if (we[SL_MEM_LIM+1])  memLimF[11:4]  <= wd[SL_MEM_LIM+1];
      if (we[SL_PF_BASE])    pfBaseF[3:0]   <= wd[SL_PF_BASE][7:4];
      if (we[SL_PF_BASE+1])  pfBaseF[11:4]  <= wd[SL_PF_BASE+1];
      if (we[SL_PF_LIM])     pfLimF[3:0]    <= wd[SL_PF_LIM][7:4];
      if (we[SL_PF_LIM+1])   pfLimF[11:4]   <= wd[SL_PF_LIM+1];
      for (int b = 0; b < 2; b++) begin
        if (we[SL_IO_BASE_UP+b]) ioBaseUp[8*b +: 8] <= wd[SL_IO_BASE_UP+b];
        if (we[SL_IO_LIM_UP+b])  ioLimUp[8*b +: 8]  <= wd[SL_IO_LIM_UP+b];
      end
      for (int b = 0; b < 4; b++) begin
        if (we[SL_PF_BASE_UP+b]) pfBaseUp[8*b +: 8] <= wd[SL_PF_BASE_UP+b];
        if (we[SL_PF_LIM_UP+b])  pfLimUp[8*b +: 8]  <= wd[SL_PF_LIM_UP+b];
      end
    end
  end

  // Full window addresses, indexed by space code.
  logic [NUM_SPACES-1:0][QAW-1:0] winBase, winLim;
  logic [NUM_SPACES-1:0]          winOn;

  always_comb begin
    winBase[SPACE_IO] = {32'b0, (ioBaseWide ? ioBaseUp : 16'b0), ioBaseNib,
                         {IO_GRAN_BITS{1'b0}}};
    winLim[SPACE_IO]  = {32'b0, (ioLimWide ? ioLimUp : 16'b0), ioLimNib,
                         {IO_GRAN_BITS{1'b1}}};
    winBase[SPACE_MEM] = {32'b0, memBaseF, {MEM_GRAN_BITS{1'b0}}};
    winLim[SPACE_MEM]  = {32'b0, memLimF, {MEM_GRAN_BITS{1'b1}}};
    winBase[SPACE_PREF] = {pfBaseUp, pfBaseF, {MEM_GRAN_BITS{1'b0}}};
    winLim[SPACE_PREF]  = {pfLimUp, pfLimF, {MEM_GRAN_BITS{1'b1}}};
    winBase[SPACE_NONE] = '1;
    winLim[SPACE_NONE]  = '0;
    winOn[SPACE_IO]   = ioEnable;
    winOn[SPACE_MEM]  = memEnable;
    winOn[SPACE_PREF] = memEnable;
    winOn[SPACE_NONE] = 1'b0;
  end

  assign qHit = winOn[qSpace] && (qAddr >= winBase[qSpace]) &&
                (qAddr <= winLim[qSpace]);

  // Range clip against the selected window.
  logic [QAW:0]   reqEndWide;
  logic [QAW-1:0] reqEnd, selBase, selLim, cutLo, cutHi, cutSize;
  logic           cutOk;

  always_comb begin
    reqEndWide = {1'b0, clipBase} + {1'b0, clipSize} - (QAW+1)'(1);
    reqEnd  = reqEndWide[QAW] ? '1 : reqEndWide[QAW-1:0];
    selBase = winBase[clipSpace];
    selLim  = winLim[clipSpace];
    cutLo   = (clipBase > selBase) ? clipBase : selBase;
    cutHi   = (reqEnd < selLim) ? reqEnd : selLim;
    cutOk   = winOn[clipSpace] && (clipSize != '0) && (cutLo <= cutHi);
    cutSize = cutHi - cutLo + QAW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clipMapped  <= 1'b0;
      clipOutBase <= '1;
      clipOutSize <= '0;
    end else if (strobe.clipLoad) begin
      clipMapped  <= cutOk;
      clipOutBase <= cutOk ? cutLo : '1;
      clipOutSize <= cutOk ? cutSize : '0;
    end
  end
endmodule

// File: rtl/fwd_window_decoder.sv
module fwd_window_decoder
  import fwdwin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgWide,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_DW-1:0] cfgData,
  input  logic              ioEnable,
  input  logic              memEnable,
  input  logic [1:0]        qSpace,
  input  logic [QAW-1:0]    qAddr,
  output logic              qHit,
  input  logic              clipReq,
  input  logic [1:0]        clipSpace,
  input  logic [QAW-1:0]    clipBase,
  input  logic [QAW-1:0]    clipSize,
  output logic              cfgUpdate,
  output logic              clipValid,
  output logic              clipMapped,
  output logic [QAW-1:0]    clipOutBase,
  output logic [QAW-1:0]    clipOutSize
);
  ctrl_strobe_t strobe;

  fwdwin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWide(cfgWide),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .clipReq(clipReq),
    .strobe(strobe), .cfgUpdate(cfgUpdate), .clipValid(clipValid)
  );

  fwdwin_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioEnable(ioEnable),
    .memEnable(memEnable), .qSpace(space_e'(qSpace)), .qAddr(qAddr),
    .qHit(qHit), .clipSpace(space_e'(clipSpace)), .clipBase(clipBase),
    .clipSize(clipSize), .clipMapped(clipMapped),
    .clipOutBase(clipOutBase), .clipOutSize(clipOutSize)
  );
endmodule

// File: rtl/fwdwin_checker.sv
module fwdwin_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [7:0]  cfgAddr,
  input logic        ioEnable,
  input logic        memEnable,
  input logic [1:0]  qSpace,
  input logic        qHit,
  input logic        clipReq,
  input logic [1:0]  clipSpace,
  input logic        cfgUpdate,
  input logic        clipValid,
  input logic        clipMapped,
  input logic [63:0] clipOutBase,
  input logic [63:0] clipOutSize
);
  AST_UPD_AFTER_MEMWR: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && cfgAddr >= 8'h20 && cfgAddr <= 8'h33 |=> cfgUpdate); // R8
  AST_UPD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    cfgUpdate |-> $past(cfgWrEn)); // R8
  AST_IO_GATED: assert property (@(posedge clk) disable iff (!rstN)
    qSpace == 2'd0 && !ioEnable |-> !qHit); // R6
  AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (qSpace == 2'd1 || qSpace == 2'd2) && !memEnable |-> !qHit); // R6
  AST_NONE_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    qSpace == 2'd3 |-> !qHit); // R6
  AST_CLIP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    clipReq |=> clipValid); // R9
  AST_CLIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !clipReq |=> !clipValid); // R9
  AST_MAPPED_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    clipValid && clipMapped |-> clipOutSize != 64'd0); // R9
  AST_UNMAPPED_FORM: assert property (@(posedge clk) disable iff (!rstN)
    clipValid && !clipMapped |-> clipOutSize == 64'd0 && &clipOutBase); // R10
  AST_DISABLED_CLIP: assert property (@(posedge clk) disable iff (!rstN)
    clipReq && clipSpace == 2'd0 && !ioEnable |=> !clipMapped); // R10
endmodule

bind fwd_window_decoder fwdwin_checker u_fwdwin_checker (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .ioEnable(ioEnable), .memEnable(memEnable), .qSpace(qSpace), .qHit(qHit),
  .clipReq(clipReq), .clipSpace(clipSpace), .cfgUpdate(cfgUpdate),
  .clipValid(clipValid), .clipMapped(clipMapped),
  .clipOutBase(clipOutBase), .clipOutSize(clipOutSize)
);

// File: tb/tb_fwd_window_decoder.sv
`timescale 1ns/1ps
module tb_fwd_window_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgWide = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        ioEnable = 1'b1, memEnable = 1'b1;
  logic [1:0]  qSpace = '0;
  logic [63:0] qAddr = '0;
  logic        qHit;
  logic        clipReq = 1'b0;
  logic [1:0]  clipSpace = '0;
  logic [63:0] clipBase = '0, clipSize = '0;
  logic        cfgUpdate, clipValid, clipMapped;
  logic [63:0] clipOutBase, clipOutSize;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    logic        mapped;
    logic [63:0] base;
    logic [63:0] size;
    string       tag;
  } clip_item_t;
  clip_item_t sbq[$];

  always #4 clk = ~clk;

  fwd_window_decoder dut (.*);

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [7:0] a, logic [15:0] d, bit wide, bit expUpd, string tag);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgData = d; cfgWide = wide;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWide = 1'b0;
    check(cfgUpdate == expUpd, {tag, " update strobe"}, 64'(cfgUpdate), 64'(expUpd));
  endtask

  task automatic probe(logic [1:0] sp, logic [63:0] a, bit expHit, string tag);
    qSpace = sp; qAddr = a;
    #1;
    check(qHit == expHit, tag, 64'(qHit), 64'(expHit));
  endtask

  task automatic clip(logic [1:0] sp, logic [63:0] b, logic [63:0] s,
                      bit m, logic [63:0] eb, logic [63:0] es, string tag);
    clip_item_t it;
    @(negedge clk);
    it.mapped = m; it.base = eb; it.size = es; it.tag = tag;
    sbq.push_back(it);
    clipReq = 1'b1; clipSpace = sp; clipBase = b; clipSize = s;
    @(negedge clk);
    clipReq = 1'b0;
  endtask

  // Monitor: compares each clip result against the oldest expected item.
  always @(negedge clk) begin
    if (rstN && clipValid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R9 unexpected clip result", 64'(1), 64'(0));
      end else begin
        clip_item_t e;
        e = sbq.pop_front();
        check(clipMapped == e.mapped, {e.tag, " mapped"}, 64'(clipMapped), 64'(e.mapped));
        check(clipOutBase == e.base, {e.tag, " base"}, clipOutBase, e.base);
        check(clipOutSize == e.size, {e.tag, " size"}, clipOutSize, e.size);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cfgUpdate == 1'b0, "R1 no strobe after reset", 64'(cfgUpdate), 64'(0));
    check(clipValid == 1'b0, "R1 no clip result after reset", 64'(clipValid), 64'(0));
    probe(2'd0, 64'h0, 1'b0, "R1 io addr 0");
    probe(2'd0, 64'hF000, 1'b0, "R1 io addr F000");
    probe(2'd1, 64'h0, 1'b0, "R1 mem addr 0");
    probe(2'd2, 64'hFFF0_0000, 1'b0, "R1 pref addr");
    clip(2'd0, 64'h0, 64'h1_0000, 1'b0, '1, 64'h0, "R1 clip on empty io window");

    // R2: 16-bit I/O window
    cfgWrite(8'h1C, 16'h0020, 1'b0, 1'b1, "R8 io base byte");
    cfgWrite(8'h1D, 16'h0030, 1'b0, 1'b1, "R8 io limit byte");
    probe(2'd0, 64'h2000, 1'b1, "R11 io hit first cycle after write");
    probe(2'd0, 64'h1FFF, 1'b0, "R2 below io base");
    probe(2'd0, 64'h3FFF, 1'b1, "R2 io limit with ones");
    probe(2'd0, 64'h4000, 1'b0, "R2 above io limit");
    ioEnable = 1'b0;
    probe(2'd0, 64'h2000, 1'b0, "R6 io disabled");
    ioEnable = 1'b1;

    // R3: upper register ignored while bit 0 clear, used when set
    cfgWrite(8'h30, 16'h0001, 1'b1, 1'b1, "R8 io base upper");
    cfgWrite(8'h32, 16'h0001, 1'b1, 1'b1, "R8 io limit upper");
    probe(2'd0, 64'h2000, 1'b1, "R3 upper ignored while narrow");
    probe(2'd0, 64'h1_2000, 1'b0, "R3 upper not applied while narrow");
    cfgWrite(8'h1C, 16'h0021, 1'b0, 1'b1, "R8 io base wide");
    cfgWrite(8'h1D, 16'h0031, 1'b0, 1'b1, "R8 io limit wide");
    probe(2'd0, 64'h1_2000, 1'b1, "R3 wide io base");
    probe(2'd0, 64'h1_3FFF, 1'b1, "R3 wide io limit");
    probe(2'd0, 64'h2000, 1'b0, "R3 low page now outside");
    probe(2'd0, 64'h1_4000, 1'b0, "R3 above wide limit");

    // R7: write outside window bytes, then a 16-bit write over both I/O bytes
    cfgWrite(8'h1E, 16'h00FF, 1'b0, 1'b0, "R8 no strobe for 0x1E");
    probe(2'd0, 64'h1_2000, 1'b1, "R7 window unchanged by 0x1E write");
    cfgWrite(8'h1C, 16'h5040, 1'b1, 1'b1, "R8 io word write");
    probe(2'd0, 64'h4000, 1'b1, "R7 word write low byte to base");
    probe(2'd0, 64'h5FFF, 1'b1, "R7 word write high byte to limit");
    probe(2'd0, 64'h6000, 1'b0, "R7 above new limit");

    // R4: memory window, low nibble ignored
    cfgWrite(8'h20, 16'h1235, 1'b1, 1'b1, "R8 mem base");
    cfgWrite(8'h22, 16'h1240, 1'b1, 1'b1, "R8 mem limit");
    probe(2'd1, 64'h1230_0000, 1'b1, "R4 mem base");
    probe(2'd1, 64'h122F_FFFF, 1'b0, "R4 below mem base");
    probe(2'd1, 64'h124F_FFFF, 1'b1, "R4 mem limit ones");
    probe(2'd1, 64'h1250_0000, 1'b0, "R4 above mem limit");
    probe(2'd3, 64'h1230_0000, 1'b0, "R6 space none");

    // R5: prefetchable window with upper halves
    cfgWrite(8'h24, 16'h0010, 1'b1, 1'b1, "R8 pref base");
    cfgWrite(8'h26, 16'h0020, 1'b1, 1'b1, "R8 pref limit");
    cfgWrite(8'h28, 16'h0002, 1'b1, 1'b1, "R8 pref base upper lo");
    cfgWrite(8'h2A, 16'h0000, 1'b1, 1'b1, "R8 pref base upper hi");
    cfgWrite(8'h2C, 16'h0002, 1'b1, 1'b1, "R8 pref limit upper lo");
    cfgWrite(8'h2E, 16'h0000, 1'b1, 1'b1, "R8 pref limit upper hi");
    probe(2'd2, 64'h2_0010_0000, 1'b1, "R5 pref base");
    probe(2'd2, 64'h0_0010_0000, 1'b0, "R5 upper half differs");
    probe(2'd2, 64'h2_002F_FFFF, 1'b1, "R5 pref limit");
    probe(2'd2, 64'h2_0030_0000, 1'b0, "R5 above pref limit");
    probe(2'd1, 64'h2_0010_0000, 1'b0, "R6 mem space misses pref addr");
    memEnable = 1'b0;
    probe(2'd2, 64'h2_0010_0000, 1'b0, "R6 pref disabled");
    probe(2'd1, 64'h1230_0000, 1'b0, "R6 mem disabled");
    memEnable = 1'b1;

    // R9 / R10: clipping
    clip(2'd1, 64'h1220_0000, 64'h0020_0000, 1'b1, 64'h1230_0000, 64'h0010_0000, "R9 clip low side");
    clip(2'd1, 64'h1240_0000, 64'h0040_0000, 1'b1, 64'h1240_0000, 64'h0010_0000, "R9 clip high side");
    clip(2'd0, 64'h4800, 64'h10, 1'b1, 64'h4800, 64'h10, "R9 clip inside io");
    clip(2'd2, 64'h2_0000_0000, 64'h1_0000_0000, 1'b1, 64'h2_0010_0000, 64'h20_0000, "R9 clip pref page");
    clip(2'd0, 64'h6000, 64'h100, 1'b0, '1, 64'h0, "R10 no overlap");
    clip(2'd1, 64'h1230_0000, 64'h0, 1'b0, '1, 64'h0, "R10 zero size");
    clip(2'd3, 64'h1230_0000, 64'h10, 1'b0, '1, 64'h0, "R10 space none");
    clip(2'd1, 64'hFFFF_FFFF_FFFF_F000, 64'h2000, 1'b0, '1, 64'h0, "R10 saturated end");
    memEnable = 1'b0;
    clip(2'd1, 64'h1230_0000, 64'h10, 1'b0, '1, 64'h0, "R10 mem disabled");
    memEnable = 1'b1;

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R9 all clip results returned", 64'(sbq.size()), 64'(0));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule